// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block produces the status a parallel NOR flash shows to its host while an internal program or erase algorithm runs. A decoded command arrives as a one-cycle start pulse carrying the operation kind and a flag saying whether the target is write-protected. The block then holds the ready line low. On each host read it flips a toggle bit. It latches a timeout flag when the algorithm reports that its pulse count ran out. It raises an erase-timer flag for a sector erase.

When the target is protected, the block does not wait for the algorithm. It runs a fixed window counted in clock cycles and then returns to read mode. A program uses a window of about 2 µs and an erase uses about 100 µs. A reset command drops all status in one cycle. The host uses `status_mode_o` to decide whether a read returns status or array data.

Top module: `flash_status_top`

## Requirements
- R1: After synchronous reset, `ready_o`=1, `toggle_o`=0, `timeout_o`=0, `etimer_o`=0 and `status_mode_o`=0.
- R2: A start pulse accepted while idle drives `ready_o` low and `status_mode_o` high from the next cycle. Both stay that way until the cycle after `alg_done_i` is seen. Operation codes on `op_i` are 2'b01 program, 2'b10 sector erase, 2'b11 chip erase and 2'b00 none.
- R3: While not idle, the toggle bit inverts once for each rising edge of the read condition (`ce_n_i`=0 and `oe_n_i`=0 together). A strobe with only one of the two enables low does not change it.
- R4: Every accepted start clears the toggle bit to 0 in the next cycle.
- R5: While idle, reads leave the toggle bit unchanged.
- R6: A program to a protected target keeps `ready_o` low for exactly PROG_WIN = (CLK_HZ/1e6)×PROG_ABORT_US cycles, with the toggle active. It then returns to idle without consulting the algorithm.
- R7: A sector or chip erase whose targets are all protected keeps `ready_o` low for exactly ERASE_WIN = (CLK_HZ/1e6)×ERASE_ABORT_US cycles.
- R8: `alg_fail_i` during a running algorithm sets `timeout_o`=1. After that, `ready_o` stays low, `alg_done_i` has no effect and the toggle bit keeps inverting on reads, until a reset command arrives.
- R9: `etimer_o` is 1 from the cycle after a sector-erase start until the operation ends. It stays 0 for program and chip erase.
- R10: `reset_cmd_i` while not idle returns the block to idle with `timeout_o` and `etimer_o` at 0 in the next cycle. While idle, `reset_cmd_i` changes no output.
- R11: A start pulse while not idle, or a start with operation code 2'b00, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of a decoded operation |
| op_i | input | 2 | Operation kind (01 program, 10 sector erase, 11 chip erase) |
| prot_i | input | 1 | Target protected, valid with `start_i` |
| alg_done_i | input | 1 | Algorithm finished successfully |
| alg_fail_i | input | 1 | Algorithm exceeded its pulse-count limit |
| reset_cmd_i | input | 1 | Reset command from the decoder |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| ready_o | output | 1 | High when ready, low while an operation holds the block busy |
| toggle_o | output | 1 | Toggle status bit |
| timeout_o | output | 1 | Exceeded-limit status bit |
| etimer_o | output | 1 | Sector-erase-started status bit |
| status_mode_o | output | 1 | Reads return status instead of array data |

## Verification
The bench builds the block with CLK_HZ = 4 MHz and keeps the default window lengths in microseconds. That shrinks the protected-program abort to 8 cycles and the protected-erase abort to 400 cycles. Both windows can then be measured cycle by cycle to their last busy cycle. The error-free run, the timeout lock, and the reset and ignored-start corner cases also fit comfortably in one short run.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SERASE = 2'b10,
        OP_CERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_ABORT = 2'b10,
        ST_FAIL  = 2'b11
    } st_e;

    // cycles spanned by a window of 'us' microseconds at 'hz', never below one
    function automatic int win_cycles(input int hz, input int us);
        int c;
        c = (hz / 1000000) * us;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_abort_timer.sv
module flash_abort_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_toggle_unit.sv
module flash_toggle_unit (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic tog_o
);
    logic rd_act, rd_q, tog_q;

    assign rd_act = ~ce_n_i & ~oe_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (clr_i)                       tog_q <= 1'b0;
            else if (en_i && rd_act && !rd_q) tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/flash_status_fsm.sv
module flash_status_fsm
    import flash_status_pkg::*;
#(
    parameter int CW        = 8,
    parameter int PROG_WIN  = 8,
    parameter int ERASE_WIN = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  op_e           op_i,
    input  logic          prot_i,
    input  logic          done_i,
    input  logic          fail_i,
    input  logic          rcmd_i,
    input  logic          tmr_zero_i,
    output st_e           state_o,
    output logic          accept_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          tmr_dec_o,
    output logic          timeout_o,
    output logic          etimer_o
);
    st_e  state_q;
    logic to_q, et_q;

    assign accept_o   = (state_q == ST_IDLE) && start_i && (op_i != OP_NONE);
    assign tmr_load_o = accept_o && prot_i;
    assign tmr_val_o  = (op_i == OP_PROG) ? CW'(PROG_WIN - 1) : CW'(ERASE_WIN - 1);
    assign tmr_dec_o  = (state_q == ST_ABORT) && !tmr_zero_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            to_q    <= 1'b0;
            et_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        et_q    <= (op_i == OP_SERASE);
                        state_q <= prot_i ? ST_ABORT : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (rcmd_i) begin
                        state_q <= ST_IDLE;
                        et_q    <= 1'b0;
                    end else if (fail_i) begin
                        state_q <= ST_FAIL;
                        to_q    <= 1'b1;
                    end else if (done_i) begin
                        state_q <= ST_IDLE;
                        et_q    <= 1'b0;
                    end
                end
                ST_ABORT: begin
                    if (rcmd_i || tmr_zero_i) begin
                        state_q <= ST_IDLE;
                        et_q    <= 1'b0;
                    end
                end
                ST_FAIL: begin
                    if (rcmd_i) begin
                        state_q <= ST_IDLE;
                        to_q    <= 1'b0;
                        et_q    <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state_q;
    assign timeout_o = to_q;
    assign etimer_o  = et_q;
endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
    import flash_status_pkg::*;
#(
    parameter int CLK_HZ         = 50000000,
    parameter int PROG_ABORT_US  = 2,
    parameter int ERASE_ABORT_US = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] op_i,
    input  logic       prot_i,
    input  logic       alg_done_i,
    input  logic       alg_fail_i,
    input  logic       reset_cmd_i,
    input  logic       ce_n_i,
    input  logic       oe_n_i,
    output logic       ready_o,
    output logic       toggle_o,
    output logic       timeout_o,
    output logic       etimer_o,
    output logic       status_mode_o
);
    localparam int PROG_WIN  = win_cycles(CLK_HZ, PROG_ABORT_US);
    localparam int ERASE_WIN = win_cycles(CLK_HZ, ERASE_ABORT_US);
    localparam int CW        = $clog2(imax(PROG_WIN, ERASE_WIN) + 1);

    st_e           state;
    logic          accept, tmr_load, tmr_dec, tmr_zero, active;
    logic [CW-1:0] tmr_val;

    flash_status_fsm #(
        .CW(CW), .PROG_WIN(PROG_WIN), .ERASE_WIN(ERASE_WIN)
    ) fsm_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_e'(op_i)),
        .prot_i(prot_i), .done_i(alg_done_i), .fail_i(alg_fail_i),
        .rcmd_i(reset_cmd_i), .tmr_zero_i(tmr_zero), .state_o(state),
        .accept_o(accept), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .tmr_dec_o(tmr_dec), .timeout_o(timeout_o), .etimer_o(etimer_o)
    );

    flash_abort_timer #(.CW(CW)) tmr_i (
        .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val),
        .dec_i(tmr_dec), .zero_o(tmr_zero)
    );

    assign active = (state != ST_IDLE);

    flash_toggle_unit tog_i (
        .clk(clk), .rst(rst), .clr_i(accept), .en_i(active),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .tog_o(toggle_o)
    );

    assign ready_o       = ~active;
    assign status_mode_o = active;
endmodule

// File: rtl/flash_status_checker.sv
module flash_status_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [1:0] op_i,
    input logic       reset_cmd_i,
    input logic       ready_o,
    input logic       toggle_o,
    input logic       timeout_o,
    input logic       etimer_o
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i && op_i != 2'b00) |=> !ready_o);                 // R2
    AST_START_TOG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i && op_i != 2'b00) |=> !toggle_o);                // R4
    AST_IDLE_TOG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> $stable(toggle_o));                        // R5
    AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (timeout_o && !reset_cmd_i) |=> timeout_o);                          // R8
    AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !ready_o);                                             // R8
    AST_CHIP_NO_ETIMER: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i && op_i == 2'b11) |=> !etimer_o);                // R9
    AST_RCMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && reset_cmd_i) |=> (ready_o && !timeout_o && !etimer_o)); // R10
endmodule

bind flash_status_top flash_status_checker chk_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .reset_cmd_i(reset_cmd_i), .ready_o(ready_o), .toggle_o(toggle_o),
    .timeout_o(timeout_o), .etimer_o(etimer_o)
);

// File: tb/flash_status_top_tb_top.sv
module flash_status_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 4000000;
    localparam int PW = (HZ / 1000000) * 2;    // 8
    localparam int EW = (HZ / 1000000) * 100;  // 400

    logic clk = 0, rst = 1;
    logic start_i = 0, prot_i = 0, alg_done_i = 0, alg_fail_i = 0, reset_cmd_i = 0;
    logic ce_n_i = 1, oe_n_i = 1;
    logic [1:0] op_i = 2'b00;
    logic ready_o, toggle_o, timeout_o, etimer_o, status_mode_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_top #(.CLK_HZ(HZ)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .prot_i(prot_i),
        .alg_done_i(alg_done_i), .alg_fail_i(alg_fail_i), .reset_cmd_i(reset_cmd_i),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .ready_o(ready_o), .toggle_o(toggle_o),
        .timeout_o(timeout_o), .etimer_o(etimer_o), .status_mode_o(status_mode_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 running, 2 protected window, 3 timed out
    int m_st = 0, m_cnt = 0;
    bit m_tog = 0, m_to = 0, m_et = 0, m_rdp = 0;

    always @(posedge clk) begin
        bit rd, act, acc;
        rd  = !ce_n_i && !oe_n_i;
        act = (m_st != 0);
        acc = (m_st == 0) && start_i && (op_i != 2'b00);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_tog = 0; m_to = 0; m_et = 0; m_rdp = 0;
        end else begin
            if (acc) m_tog = 0;
            else if (act && rd && !m_rdp) m_tog = !m_tog;
            m_rdp = rd;
            case (m_st)
                0: if (acc) begin
                       m_et = (op_i == 2'b10);
                       if (prot_i) begin m_st = 2; m_cnt = ((op_i == 2'b01) ? PW : EW) - 1; end
                       else m_st = 1;
                   end
                1: if (reset_cmd_i) begin m_st = 0; m_et = 0; end
                   else if (alg_fail_i) begin m_st = 3; m_to = 1; end
                   else if (alg_done_i) begin m_st = 0; m_et = 0; end
                2: if (reset_cmd_i || m_cnt == 0) begin m_st = 0; m_et = 0; end
                   else m_cnt--;
                default: if (reset_cmd_i) begin m_st = 0; m_to = 0; m_et = 0; end
            endcase
            cmp_on = 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(ready_o == (m_st == 0), "R2", "model ready", ready_o, m_st == 0);
            chk(status_mode_o == (m_st != 0), "R2", "model status_mode", status_mode_o, m_st != 0);
            chk(toggle_o == m_tog, "R3", "model toggle", toggle_o, m_tog);
            chk(timeout_o == m_to, "R8", "model timeout", timeout_o, m_to);
            chk(etimer_o == m_et, "R9", "model etimer", etimer_o, m_et);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic start_op(input logic [1:0] op, input bit prot);
        @(negedge clk); start_i = 1; op_i = op; prot_i = prot;
        @(negedge clk); start_i = 0; op_i = 2'b00; prot_i = 0;
    endtask

    task automatic rd(input bit ce_only);
        @(negedge clk); ce_n_i = 0; oe_n_i = ce_only;
        @(negedge clk); ce_n_i = 1; oe_n_i = 1;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) alg_done_i = 1; else if (which == 1) alg_fail_i = 1; else reset_cmd_i = 1;
        @(negedge clk); alg_done_i = 0; alg_fail_i = 0; reset_cmd_i = 0;
    endtask

    initial begin
        int n;
        bit t;
        repeat (3) @(negedge clk);
        chk(ready_o == 1 && toggle_o == 0 && timeout_o == 0 && etimer_o == 0 && status_mode_o == 0,
            "R1", "reset outputs", {ready_o, toggle_o, timeout_o, etimer_o, status_mode_o}, 5'b10000);
        rst = 0;

        // unprotected program with reads
        start_op(2'b01, 0);
        chk(ready_o == 0, "R2", "busy after start", ready_o, 0);
        chk(toggle_o == 0, "R4", "toggle cleared", toggle_o, 0);
        rd(0); chk(toggle_o == 1, "R3", "first read", toggle_o, 1);
        rd(0); chk(toggle_o == 0, "R3", "second read", toggle_o, 0);
        rd(1); chk(toggle_o == 0, "R3", "one enable only", toggle_o, 0);
        rd(0); chk(toggle_o == 1, "R3", "third read", toggle_o, 1);
        pulse(0); chk(ready_o == 1, "R2", "ready after done", ready_o, 1);
        t = toggle_o; rd(0); rd(0);
        chk(toggle_o == t, "R5", "idle reads stable", toggle_o, t);

        // sector erase, with a start during it that must be ignored
        start_op(2'b10, 0);
        chk(etimer_o == 1, "R9", "sector erase etimer", etimer_o, 1);
        chk(toggle_o == 0, "R4", "toggle cleared again", toggle_o, 0);
        start_op(2'b01, 1);
        chk(etimer_o == 1 && ready_o == 0, "R11", "start while busy", {etimer_o, ready_o}, 2'b10);
        pulse(0);
        chk(ready_o == 1 && etimer_o == 0, "R11", "done still ends op", {ready_o, etimer_o}, 2'b10);

        // chip erase, and a start with no operation
        start_op(2'b11, 0);
        chk(etimer_o == 0, "R9", "chip erase etimer", etimer_o, 0);
        pulse(0);
        start_op(2'b00, 0);
        chk(ready_o == 1, "R11", "op none ignored", ready_o, 1);

        // protected program window with a read inside
        start_op(2'b01, 1);
        rd(0); chk(toggle_o == 1, "R6", "toggle in window", toggle_o, 1);
        n = 2;
        while (!ready_o) begin n++; @(negedge clk); end
        chk(n == PW, "R6", "program window length", n, PW);

        // protected sector erase window
        start_op(2'b10, 1);
        n = 0;
        while (!ready_o) begin n++; @(negedge clk); end
        chk(n == EW, "R7", "erase window length", n, EW);

        // timeout lock
        start_op(2'b01, 0);
        pulse(1);
        chk(timeout_o == 1 && ready_o == 0, "R8", "timeout set", {timeout_o, ready_o}, 2'b10);
        pulse(0);
        chk(timeout_o == 1 && ready_o == 0, "R8", "done ignored", {timeout_o, ready_o}, 2'b10);
        t = toggle_o; rd(0);
        chk(toggle_o != t, "R8", "toggle after timeout", toggle_o, !t);
        pulse(2);
        chk(ready_o == 1 && timeout_o == 0, "R10", "reset clears", {ready_o, timeout_o}, 2'b10);

        // reset command while idle, then during a sector erase
        t = toggle_o; pulse(2);
        chk(ready_o == 1 && toggle_o == t && timeout_o == 0 && etimer_o == 0, "R10",
            "idle reset no effect", {ready_o, toggle_o, timeout_o, etimer_o}, {1'b1, t, 2'b00});
        start_op(2'b10, 0);
        pulse(2);
        chk(ready_o == 1 && etimer_o == 0, "R10", "reset during erase", {ready_o, etimer_o}, 2'b10);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule